// File: doc/BRIEF.md
# AHCI Port Slot Dispatcher and Interrupt Merger

This block holds the control registers of a multi-port serial storage host controller: one global control register and, for each port, command, interrupt-status, interrupt-enable, link-control and command-issue registers. Software writes these through a simple write port and reads them back through a combinational read port. A port that has been started has its pending command slots handed out one at a time, lowest slot number first. Each handed-out slot appears as a one-cycle dispatch pulse carrying the port and slot numbers, and its command-issue bit is cleared.

Every port's interrupt status, filtered by that port's enable, yields one summary bit per port. Any summary bit raises the single message-signalled interrupt request, but only while the global interrupt enable is set. Event sources outside the block set status bits through `port_evt`, and software clears them by writing ones.

The dispatch scanner is a two-state machine. In `SCN_IDLE` it waits for a port with a pending scan request and takes the lowest such port (transition *claim*: floor reset to slot 0). In `SCN_RUN` it dispatches, once per cycle, the lowest issued slot at or above the floor and then moves the floor past that slot (transition *issue*). When no issued slot remains above the floor, or the port is no longer started, it returns to `SCN_IDLE` and retires that port's request (transition *retire*). A global host reset forces `SCN_IDLE` (transition *abort*).

Top module: `ahci_ctl_dispatch`

## Requirements
- R1: Dispatch happens only while the port's start bit (command bit 0) is set. Within one scan, the issued slots of a port leave in strictly ascending slot order, each exactly once, and each dispatched slot's command-issue bit reads 0 afterwards.
- R2: A dispatch loads the slot number into the current-slot field at command bits 12:8.
- R3: A write to the interrupt-enable register (port offset 0x14) stores the written value ANDed with 0xFDC000FF.
- R4: A command write (port offset 0x18) with bit 0 set sets the list-running bit (bit 15). With bit 0 clear, it clears bit 15 and the current-slot field.
- R5: The frame-receive-running bit (command bit 14) follows the receive-enable bit (bit 4) of each command write.
- R6: The list-override bit (command bit 3) always reads 0, even right after it is written as 1.
- R7: Interrupt status (port offset 0x10) is write-one-to-clear. Each `port_evt` bit sets the matching status bit, and an event wins over a clear in the same cycle.
- R8: Bit n of the global status register (host offset 0x08) is the OR of port n's status ANDed with its enable. `irq` is high when that register is nonzero and global control bit 1 is set.
- R9: Port n occupies addresses 0x100 + 0x80*n. Writes at or above 0x100 + 0x80*NPORTS change nothing, and reads there return 0.
- R10: Writing global control (host offset 0x04) with bit 0 set clears every port's registers and leaves global control at 0x80000000. This is also its reset value.
- R11: A link-control write (port offset 0x2C) is stored. If bits 3:0 equal 1 and the start bit is clear, the write also clears that port's status and command-issue registers. With start set, it leaves them unchanged.
- R12: A command-issue write (port offset 0x38) ORs bits into the register. It requests a scan of that port, and so does a command write with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| port_evt | input | 192 | Status set pulses, 32 per port, port n at bits 32n+31:32n |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_port | output | 3 | Port of the dispatched slot |
| disp_slot | output | 5 | Dispatched slot number |
| irq | output | 1 | Merged interrupt request |

## Verification
Slots issued while a port is stopped must stay put and then leave in ascending order once start is set. A design that dispatched early, skipped a slot or repeated one shows a wrong dispatch log. The bench also drives a status clear and an event into the same bit in the same cycle, where a design that lets the clear win loses an interrupt. A link reset is tried with start set, where a design that ignored the start gate would wipe pending status. It writes past the last port, where a sloppy decode aliases onto port 0. Finally it checks that a host reset drops `irq` and all port state together.

// File: rtl/ahci_disp_pkg.sv
package ahci_disp_pkg;

    localparam int SLOTS  = 32;
    localparam int SLOT_W = 5;

    localparam logic [31:0] IE_KEEP = 32'hFDC0_00FF;

    // offsets inside one port window
    localparam logic [6:0] OFF_STAT = 7'h10;
    localparam logic [6:0] OFF_EN   = 7'h14;
    localparam logic [6:0] OFF_CMD  = 7'h18;
    localparam logic [6:0] OFF_LINK = 7'h2C;
    localparam logic [6:0] OFF_ISS  = 7'h38;

    // command register bit positions
    localparam int B_START = 0;
    localparam int B_RXEN  = 4;
    localparam int B_RXRUN = 14;
    localparam int B_LRUN  = 15;

    typedef enum logic [0:0] {SCN_IDLE, SCN_RUN} scan_state_t;

    // index of lowest set bit, SLOTS when none
    function automatic logic [SLOT_W:0] low_slot(input logic [SLOTS-1:0] v);
        logic [SLOT_W:0] r;
        r = (SLOT_W+1)'(SLOTS);
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = (SLOT_W+1)'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ahci_port_regs.sv
module ahci_port_regs
    import ahci_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              wr_sel,
    input  logic [6:0]        wr_off,
    input  logic [31:0]       wr_data,
    input  logic [SLOTS-1:0]  evt,
    input  logic              disp_hit,
    input  logic [SLOT_W-1:0] disp_slot,
    output logic [31:0]       stat_q,
    output logic [31:0]       en_q,
    output logic [31:0]       cmd_rd,
    output logic [31:0]       link_q,
    output logic [SLOTS-1:0]  iss_q,
    output logic              kick,
    output logic              started,
    output logic              port_irq
);

    logic              st_q, rxen_q, rxrun_q, lrun_q;
    logic [SLOT_W-1:0] cur_q;
    logic              w_stat, w_en, w_cmd, w_link, w_iss, link_rst;

    always_comb begin
        w_stat   = wr_sel && (wr_off == OFF_STAT);
        w_en     = wr_sel && (wr_off == OFF_EN);
        w_cmd    = wr_sel && (wr_off == OFF_CMD);
        w_link   = wr_sel && (wr_off == OFF_LINK);
        w_iss    = wr_sel && (wr_off == OFF_ISS);
        link_rst = w_link && (wr_data[3:0] == 4'h1) && !st_q;
        kick     = w_iss || (w_cmd && wr_data[B_START]);
        started  = st_q;
        port_irq = |(stat_q & en_q);
        cmd_rd   = '0;
        cmd_rd[B_START]  = st_q;
        cmd_rd[B_RXEN]   = rxen_q;
        cmd_rd[12:8]     = cur_q;
        cmd_rd[B_RXRUN]  = rxrun_q;
        cmd_rd[B_LRUN]   = lrun_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) begin
            stat_q  <= '0;
            en_q    <= '0;
            link_q  <= '0;
            iss_q   <= '0;
            st_q    <= 1'b0;
            rxen_q  <= 1'b0;
            rxrun_q <= 1'b0;
            lrun_q  <= 1'b0;
            cur_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~(w_stat ? wr_data : 32'h0)) | evt;
            iss_q  <= (iss_q & ~(disp_hit ? (SLOTS'(1) << disp_slot) : '0))
                      | (w_iss ? wr_data : 32'h0);
            if (w_en)   en_q   <= wr_data & IE_KEEP;
            if (w_link) link_q <= wr_data;
            if (w_cmd) begin
                st_q    <= wr_data[B_START];
                rxen_q  <= wr_data[B_RXEN];
                rxrun_q <= wr_data[B_RXEN];
                if (wr_data[B_START]) begin
                    lrun_q <= 1'b1;
                end else begin
                    lrun_q <= 1'b0;
                    cur_q  <= '0;
                end
            end else if (disp_hit) begin
                cur_q <= disp_slot;
            end
            if (link_rst) begin
                stat_q <= '0;
                iss_q  <= '0;
            end
        end
    end

    AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        w_en |=> en_q == ($past(wr_data) & IE_KEEP));                      // R3
    AST_LRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_cmd && !wr_data[B_START]) |=> (!lrun_q && cur_q == '0));         // R4
    AST_RXRUN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        w_cmd |=> rxrun_q == $past(wr_data[B_RXEN]));                       // R5
    AST_LINK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (w_link && st_q && evt == '0) |=> stat_q == $past(stat_q));         // R11

endmodule

// File: rtl/ahci_slot_scanner.sv
module ahci_slot_scanner
    import ahci_disp_pkg::*;
#(
    parameter int NPORTS = 6,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_rst,
    input  logic [NPORTS-1:0]            kick,
    input  logic [NPORTS-1:0]            started,
    input  logic [NPORTS-1:0][SLOTS-1:0] iss,
    output logic                         disp_valid,
    output logic [PW-1:0]                disp_port,
    output logic [SLOT_W-1:0]            disp_slot
);

    scan_state_t       state_q, state_d;
    logic [PW-1:0]     cur_q, cur_d;
    logic [SLOT_W:0]   floor_q, floor_d;
    logic [NPORTS-1:0] pend_q;
    logic [SLOTS-1:0]  above;
    logic [SLOT_W:0]   pick;
    logic              hit, retire;

    function automatic logic [PW-1:0] low_port(input logic [NPORTS-1:0] v);
        logic [PW-1:0] r;
        r = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (v[i]) r = PW'(i);
        end
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < SLOTS; i++) above[i] = ((SLOT_W+1)'(i) >= floor_q);
        pick   = low_slot(iss[cur_q] & above);
        hit    = (state_q == SCN_RUN) && started[cur_q] && !pick[SLOT_W];
        retire = (state_q == SCN_RUN) && !hit;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        floor_d = floor_q;
        unique case (state_q)
            SCN_IDLE: if (|pend_q) begin
                state_d = SCN_RUN;
                cur_d   = low_port(pend_q);
                floor_d = '0;
            end
            SCN_RUN: if (hit) floor_d = pick + 1'b1;
                     else     state_d = SCN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) begin
            state_q <= SCN_IDLE;
            cur_q   <= '0;
            floor_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            floor_q <= floor_d;
            pend_q  <= (pend_q & ~(retire ? (NPORTS'(1) << cur_q) : '0)) | kick;
        end
    end

    // outputs
    always_comb begin
        disp_valid = hit;
        disp_port  = cur_q;
        disp_slot  = pick[SLOT_W-1:0];
    end

    AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && $past(disp_valid) && disp_port == $past(disp_port))
            |-> disp_slot > $past(disp_slot));                              // R1

endmodule

// File: rtl/ahci_irq_merge.sv
module ahci_irq_merge #(
    parameter int NPORTS = 6
) (
    input  logic [NPORTS-1:0] port_irq,
    input  logic              glob_en,
    output logic [NPORTS-1:0] glob_stat,
    output logic              irq
);

    always_comb begin
        glob_stat = port_irq;
        irq       = glob_en && (|glob_stat);
    end

endmodule

// File: rtl/ahci_ctl_dispatch.sv
module ahci_ctl_dispatch
    import ahci_disp_pkg::*;
#(
    parameter int NPORTS = 6,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int AW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [31:0]             wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [31:0]             rd_data,
    input  logic [NPORTS*SLOTS-1:0] port_evt,
    output logic                    disp_valid,
    output logic [PW-1:0]           disp_port,
    output logic [SLOT_W-1:0]       disp_slot,
    output logic                    irq
);

    localparam logic [AW-1:0] PORT_BASE = AW'(12'h100);
    localparam logic [AW:0]   PORT_END  = (AW+1)'(256 + NPORTS * 128);
    localparam logic [AW-1:0] A_CTRL    = AW'(12'h004);
    localparam logic [AW-1:0] A_GSTAT   = AW'(12'h008);

    logic                         ctrl_wr, host_rst, glob_en_q;
    logic                         w_in, r_in;
    logic [AW-1:0]                w_rel, r_rel;
    logic [NPORTS-1:0]            w_sel, kick, started, port_irq, glob_stat, hit;
    logic [NPORTS-1:0][SLOTS-1:0] iss;
    logic [NPORTS-1:0][31:0]      stat_v, en_v, cmd_v, link_v;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        host_rst = ctrl_wr && wr_data[0];
        w_in     = (wr_addr >= PORT_BASE) && ({1'b0, wr_addr} < PORT_END);
        r_in     = (rd_addr >= PORT_BASE) && ({1'b0, rd_addr} < PORT_END);
        w_rel    = wr_addr - PORT_BASE;
        r_rel    = rd_addr - PORT_BASE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) glob_en_q <= 1'b0;
        else if (ctrl_wr)       glob_en_q <= wr_data[1];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign w_sel[p] = wr_en && w_in && (w_rel[AW-1:7] == (AW-7)'(p));
        assign hit[p]   = disp_valid && (disp_port == PW'(p));
        ahci_port_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_rst (host_rst),
            .wr_sel   (w_sel[p]),
            .wr_off   (wr_addr[6:0]),
            .wr_data  (wr_data),
            .evt      (port_evt[p*SLOTS +: SLOTS]),
            .disp_hit (hit[p]),
            .disp_slot(disp_slot),
            .stat_q   (stat_v[p]),
            .en_q     (en_v[p]),
            .cmd_rd   (cmd_v[p]),
            .link_q   (link_v[p]),
            .iss_q    (iss[p]),
            .kick     (kick[p]),
            .started  (started[p]),
            .port_irq (port_irq[p])
        );
    end

    ahci_slot_scanner #(.NPORTS(NPORTS)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_rst  (host_rst),
        .kick      (kick),
        .started   (started),
        .iss       (iss),
        .disp_valid(disp_valid),
        .disp_port (disp_port),
        .disp_slot (disp_slot)
    );

    ahci_irq_merge #(.NPORTS(NPORTS)) u_irq (
        .port_irq (port_irq),
        .glob_en  (glob_en_q),
        .glob_stat(glob_stat),
        .irq      (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data = {1'b1, 29'h0, glob_en_q, 1'b0};
        end else if (rd_addr == A_GSTAT) begin
            rd_data = 32'(glob_stat);
        end else if (r_in) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (r_rel[AW-1:7] == (AW-7)'(p)) begin
                    case (rd_addr[6:0])
                        OFF_STAT: rd_data = stat_v[p];
                        OFF_EN:   rd_data = en_v[p];
                        OFF_CMD:  rd_data = cmd_v[p];
                        OFF_LINK: rd_data = link_v[p];
                        OFF_ISS:  rd_data = iss[p];
                        default:  rd_data = '0;
                    endcase
                end
            end
        end
    end

    AST_HR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> !irq);                                                 // R10

endmodule

// File: tb/ahci_ctl_dispatch_bench.sv
module ahci_ctl_dispatch_bench;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP*32-1:0] port_evt = '0;
    logic          disp_valid;
    logic [2:0]    disp_port;
    logic [4:0]    disp_slot;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int nlog = 0;
    logic [2:0] log_port [16];
    logic [4:0] log_slot [16];

    always #4 clk = ~clk;

    ahci_ctl_dispatch u_ahci_ctl_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .port_evt(port_evt), .disp_valid(disp_valid), .disp_port(disp_port),
        .disp_slot(disp_slot), .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n && disp_valid && nlog < 16) begin
            log_port[nlog] = disp_port;
            log_slot[nlog] = disp_slot;
            nlog++;
        end
    end

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'h194, 32'hFFFF_FFFF, 12'h194, 32'hFDC0_00FF, 8'd3},  // R3
        '{12'h198, 32'h0000_0019, 12'h198, 32'h0000_C011, 8'd6},  // R6 (R4, R5)
        '{12'h198, 32'h0000_0000, 12'h198, 32'h0000_0000, 8'd4},  // R4
        '{12'h198, 32'h0000_0010, 12'h198, 32'h0000_4010, 8'd5},  // R5
        '{12'h400, 32'hFFFF_FFFF, 12'h400, 32'h0000_0000, 8'd9},  // R9
        '{12'h004, 32'h0000_0002, 12'h004, 32'h8000_0002, 8'd8},  // R8
        '{12'h1AC, 32'h0000_0101, 12'h1AC, 32'h0000_0101, 8'd11}, // R11
        '{12'h1B8, 32'h0000_000A, 12'h1B8, 32'h0000_000A, 8'd12}  // R12
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic evt(input int bitpos);
        @(negedge clk);
        port_evt = '0;
        port_evt[bitpos] = 1'b1;
        @(negedge clk);
        port_evt = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        rd(12'h004, v); chk("R10 reset ctrl", v, 32'h8000_0000);
        chk("R8 reset irq", 32'(irq), 32'h0);
        chk("R1 reset dispatch", 32'(disp_valid), 32'h0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            checks++;
            if (v !== VECS[i].ex) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[i].req, i, v, VECS[i].ex);
            end
        end
        idle(5);
        chk("R1 no dispatch while stopped", 32'(nlog), 32'd0);

        // port 0: issue while stopped, then start
        wr(12'h138, 32'h8000_0005);
        idle(10);
        chk("R1 held while stopped", 32'(nlog), 32'd0);
        rd(12'h138, v); chk("R12 issue held", v, 32'h8000_0005);
        wr(12'h118, 32'h0000_0011);
        idle(50);
        chk("R1 dispatch count", 32'(nlog), 32'd3);
        chk("R1 first", {log_port[0], log_slot[0]}, {3'd0, 5'd0});
        chk("R1 second", {log_port[1], log_slot[1]}, {3'd0, 5'd2});
        chk("R1 third", {log_port[2], log_slot[2]}, {3'd0, 5'd31});
        rd(12'h138, v); chk("R1 issue cleared", v, 32'h0);
        rd(12'h118, v); chk("R2 current slot", v, 32'h0000_DF11);

        // port 3: start first, then issue twice
        wr(12'h298, 32'h0000_0001);
        wr(12'h2B8, 32'h0000_0030);
        idle(20);
        wr(12'h2B8, 32'h0000_0001);
        idle(20);
        chk("R12 dispatch count", 32'(nlog), 32'd6);
        chk("R12 p3 a", {log_port[3], log_slot[3]}, {3'd3, 5'd4});
        chk("R12 p3 b", {log_port[4], log_slot[4]}, {3'd3, 5'd5});
        chk("R12 p3 c", {log_port[5], log_slot[5]}, {3'd3, 5'd0});

        // interrupts on port 2
        wr(12'h214, 32'h0000_0001);
        evt(64);
        chk("R8 irq raised", 32'(irq), 32'h1);
        rd(12'h008, v); chk("R8 global status", v, 32'h0000_0004);
        rd(12'h210, v); chk("R7 status set", v, 32'h1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h210; wr_data = 32'h1; port_evt[64] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; port_evt = '0;
        rd(12'h210, v); chk("R7 event beats clear", v, 32'h1);
        wr(12'h210, 32'h1);
        rd(12'h210, v); chk("R7 cleared", v, 32'h0);
        chk("R8 irq low", 32'(irq), 32'h0);
        evt(65);
        chk("R8 masked event", 32'(irq), 32'h0);
        wr(12'h214, 32'h0000_0003);
        chk("R8 enable raises", 32'(irq), 32'h1);
        wr(12'h004, 32'h0000_0000);
        chk("R8 global gate", 32'(irq), 32'h0);
        wr(12'h004, 32'h0000_0002);

        // link reset gated by start (port 3 is started)
        evt(3*32 + 5);
        wr(12'h2AC, 32'h0000_0001);
        rd(12'h290, v); chk("R11 ignored while started", v, 32'h0000_0020);
        wr(12'h298, 32'h0000_0000);
        wr(12'h2B8, 32'h0000_0040);
        wr(12'h2AC, 32'h0000_0001);
        rd(12'h290, v); chk("R11 status wiped", v, 32'h0);
        rd(12'h2B8, v); chk("R11 issue wiped", v, 32'h0);

        // host reset
        chk("R10 irq before", 32'(irq), 32'h1);
        wr(12'h004, 32'h0000_0001);
        rd(12'h004, v); chk("R10 ctrl after reset", v, 32'h8000_0000);
        rd(12'h214, v); chk("R10 enable cleared", v, 32'h0);
        rd(12'h210, v); chk("R10 status cleared", v, 32'h0);
        chk("R10 irq dropped", 32'(irq), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule